// File: doc/BRIEF.md
# Range-Endpoint Longest-Prefix Lookup Engine

This block resolves the longest matching prefix for an address by binary search over a table of range endpoints. Each prefix occupies two table slots. The first slot holds the lowest address the prefix covers, which is the prefix bits followed by zeros. The second slot holds the highest address it covers, which is the prefix bits followed by ones. The slots are sorted in ascending key order. Every slot also carries two next-hop results that were computed ahead of time. The equal-hop applies when the address equals that slot's key. The above-hop applies when the address lies strictly between that key and the next larger one.

Because both results are stored in each slot, the search never steps back through the table to find the enclosing prefix. When the search stops, it picks one of the two results held at the deciding slot.

Lookups enter through a valid/ready request and leave as a one-cycle response that carries a next hop and a no-match flag. The table is filled through a plain write port by an outside agent, which also sorts the keys and computes both results for each slot. The table memory is a synchronous RAM with one cycle of read latency. The engine makes one read per cycle and works on one lookup at a time.

Top module: `lpm_range_lookup`

## Requirements
- R1: When `tbl_we` is high at a rising clock edge, the key, equal-hop and above-hop on the table inputs are stored in slot `tbl_idx`. Any lookup accepted after that edge uses the stored values.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the cycle in which `rsp_valid` is high. `rsp_valid` is high for exactly one cycle per accepted request.
- R3: When the address equals the key of some slot, the response carries that slot's equal-hop with `rsp_miss` = 0.
- R4: When no key equals the address and the address is above the key of slot 0, the response carries the above-hop of the largest key below the address, with `rsp_miss` = 0.
- R5: When the address is below the key of slot 0, `rsp_miss` = 1 and `rsp_hop` equals the `DEFAULT_HOP` parameter (zero by default).
- R6: The response arrives at most `LG`+1 cycles after the acceptance edge, one cycle per table read. It arrives exactly one cycle after acceptance when the address equals the key of slot 0.
- R7: Table convention and worked case. Keys are in nondecreasing order with 2^`LG` slots. A prefix's low end is zero-padded and its high end is one-padded. Each slot holds the longest-prefix result of its key as equal-hop, and the result of key+1 as above-hop. A default (no-covering-prefix) result is 0. With this convention the response equals the longest matching prefix's hop. Example with 16-bit addresses and prefixes 1*, 101*, 10101* (hops 1, 2, 3): address 0xAFFF gives 3, 0xB800 gives 2, and 0xF800 gives 1.
- R8: Unused slots hold the all-ones key, with both hops set to the result of the all-ones address. A lookup of the all-ones address then returns that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_we | input | 1 | Table slot write strobe |
| tbl_idx | input | LG | Slot index to write |
| tbl_key | input | AW | Endpoint key to store |
| tbl_eq_hop | input | HW | Result used on an exact key match |
| tbl_gt_hop | input | HW | Result used when the address is above the key |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_addr | input | AW | Address to look up |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hop | output | HW | Resolved next hop |
| rsp_miss | output | 1 | Address lies below every stored key |

## Verification
Each table is built from a random set of prefixes, some nested and some including a zero-length route. Every key is looked up exactly, which separates equal-hop selection from above-hop selection. The addresses one above and one below every key are also looked up; these show whether the search stops on the correct side of each boundary. Address zero and the all-ones address cover the below-first-slot miss and the padded slots. Random addresses, the scaled worked case, and response-latency checks complete the set; the latency checks tell the early stop on slot 0 apart from the full-depth search.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  // position of the looked-up address relative to the probed key
  typedef enum logic [1:0] {
    ORD_BELOW = 2'd0,
    ORD_EQUAL = 2'd1,
    ORD_ABOVE = 2'd2
  } ord_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_PROBE = 1'b1
  } st_e;

endpackage

// File: rtl/lpm_entry_ram.sv
module lpm_entry_ram #(
  parameter int AW = 16,
  parameter int HW = 16,
  parameter int LG = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [LG-1:0] wr_idx,
  input  logic [AW-1:0] wr_key,
  input  logic [HW-1:0] wr_eq,
  input  logic [HW-1:0] wr_gt,
  input  logic          rd_en,
  input  logic [LG-1:0] rd_idx,
  output logic [AW-1:0] rd_key,
  output logic [HW-1:0] rd_eq,
  output logic [HW-1:0] rd_gt
);
  localparam int DEPTH = 1 << LG;

  logic [AW-1:0] key_mem [DEPTH];
  logic [HW-1:0] eq_mem  [DEPTH];
  logic [HW-1:0] gt_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_mem[wr_idx] <= wr_key;
      eq_mem[wr_idx]  <= wr_eq;
      gt_mem[wr_idx]  <= wr_gt;
    end
    if (rd_en) begin
      rd_key <= key_mem[rd_idx];
      rd_eq  <= eq_mem[rd_idx];
      rd_gt  <= gt_mem[rd_idx];
    end
  end

endmodule

// File: rtl/lpm_key_cmp.sv
module lpm_key_cmp
  import lpm_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] key,
  output ord_e          ord
);

  function automatic ord_e order_of(input logic [AW-1:0] a, input logic [AW-1:0] k);
    ord_e r;
    if (a == k)     r = ORD_EQUAL;
    else if (a < k) r = ORD_BELOW;
    else            r = ORD_ABOVE;
    return r;
  endfunction

  assign ord = order_of(addr, key);

endmodule

// File: rtl/lpm_probe_fsm.sv
module lpm_probe_fsm
  import lpm_pkg::*;
#(
  parameter int            AW          = 16,
  parameter int            HW          = 16,
  parameter int            LG          = 4,
  parameter logic [HW-1:0] DEFAULT_HOP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic [AW-1:0] search_addr,
  output logic          rd_en,
  output logic [LG-1:0] rd_idx,
  input  ord_e          probe_ord,
  input  logic [HW-1:0] rd_eq,
  input  logic [HW-1:0] rd_gt,
  output logic          rsp_valid,
  output logic [HW-1:0] rsp_hop,
  output logic          rsp_miss
);
  localparam int            CW      = $clog2(LG + 2) + 1;
  localparam logic [LG-1:0] TOP_BIT = LG'(1) << (LG - 1);

  // halve the probe step; the first step after slot 0 is the top bit
  function automatic logic [LG-1:0] step_after(input logic first, input logic [LG-1:0] b);
    return first ? TOP_BIT : (b >> 1);
  endfunction

  st_e           st_q;
  logic [AW-1:0] addr_q;
  logic [LG-1:0] base_q, bit_q;
  logic          first_q;
  logic [HW-1:0] best_q;
  logic [CW-1:0] rdcnt_q;

  // named internal events
  logic          req_fire, probing, probe_eq, probe_below, probe_above;
  logic          last_probe, probe_done, miss_exit;
  logic [LG-1:0] cur_idx, base_n, bit_n;
  logic [HW-1:0] best_n;

  assign req_ready   = (st_q == ST_IDLE);
  assign req_fire    = req_valid && req_ready;
  assign search_addr = addr_q;
  assign probing     = (st_q == ST_PROBE);
  assign probe_eq    = probing && (probe_ord == ORD_EQUAL);
  assign probe_below = probing && (probe_ord == ORD_BELOW);
  assign probe_above = probing && (probe_ord == ORD_ABOVE);
  assign cur_idx     = base_q | bit_q;
  assign last_probe  = probing && !first_q && bit_q[0];
  assign miss_exit   = first_q && probe_below;
  assign probe_done  = probe_eq || miss_exit || last_probe;

  assign base_n = (probe_above && !first_q) ? cur_idx : base_q;
  assign best_n = probe_above ? rd_gt : best_q;
  assign bit_n  = step_after(first_q, bit_q);

  assign rd_en  = req_fire || (probing && !probe_done);
  assign rd_idx = probing ? (base_n | bit_n) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      base_q    <= '0;
      bit_q     <= '0;
      first_q   <= 1'b0;
      best_q    <= DEFAULT_HOP;
      rdcnt_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_hop   <= DEFAULT_HOP;
      rsp_miss  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (req_fire)   rdcnt_q <= CW'(1);
      else if (rd_en) rdcnt_q <= rdcnt_q + CW'(1);
      case (st_q)
        ST_IDLE: begin
          if (req_fire) begin
            st_q    <= ST_PROBE;
            addr_q  <= req_addr;
            base_q  <= '0;
            bit_q   <= '0;
            first_q <= 1'b1;
            best_q  <= DEFAULT_HOP;
          end
        end
        default: begin
          base_q  <= base_n;
          bit_q   <= bit_n;
          first_q <= 1'b0;
          best_q  <= best_n;
          if (probe_done) begin
            st_q      <= ST_IDLE;
            rsp_valid <= 1'b1;
            if (probe_eq) begin
              rsp_hop  <= rd_eq;
              rsp_miss <= 1'b0;
            end else if (miss_exit) begin
              rsp_hop  <= DEFAULT_HOP;
              rsp_miss <= 1'b1;
            end else begin
              rsp_hop  <= best_n;
              rsp_miss <= 1'b0;
            end
          end
        end
      endcase
    end
  end

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);
  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R3
  eq_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_eq |=> (rsp_valid && !rsp_miss && rsp_hop == $past(rd_eq)));
  // R5
  below_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (probing && first_q && probe_ord == ORD_BELOW) |=> (rsp_valid && rsp_miss));
  // R5
  miss_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_hop == DEFAULT_HOP));
  // R6
  read_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdcnt_q <= CW'(LG + 1));
  // R4
  probe_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bit_q));

endmodule

// File: rtl/lpm_range_lookup.sv
module lpm_range_lookup
  import lpm_pkg::*;
#(
  parameter int            AW          = 16,
  parameter int            HW          = 16,
  parameter int            LG          = 4,
  parameter logic [HW-1:0] DEFAULT_HOP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_we,
  input  logic [LG-1:0] tbl_idx,
  input  logic [AW-1:0] tbl_key,
  input  logic [HW-1:0] tbl_eq_hop,
  input  logic [HW-1:0] tbl_gt_hop,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [HW-1:0] rsp_hop,
  output logic          rsp_miss
);
  logic          rd_en;
  logic [LG-1:0] rd_idx;
  logic [AW-1:0] rd_key, search_addr;
  logic [HW-1:0] rd_eq, rd_gt;
  ord_e          probe_ord;

  lpm_entry_ram #(.AW(AW), .HW(HW), .LG(LG)) u_ram (
    .clk    (clk),
    .wr_en  (tbl_we),
    .wr_idx (tbl_idx),
    .wr_key (tbl_key),
    .wr_eq  (tbl_eq_hop),
    .wr_gt  (tbl_gt_hop),
    .rd_en  (rd_en),
    .rd_idx (rd_idx),
    .rd_key (rd_key),
    .rd_eq  (rd_eq),
    .rd_gt  (rd_gt)
  );

  lpm_key_cmp #(.AW(AW)) u_cmp (
    .addr (search_addr),
    .key  (rd_key),
    .ord  (probe_ord)
  );

  lpm_probe_fsm #(.AW(AW), .HW(HW), .LG(LG), .DEFAULT_HOP(DEFAULT_HOP)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .search_addr (search_addr),
    .rd_en       (rd_en),
    .rd_idx      (rd_idx),
    .probe_ord   (probe_ord),
    .rd_eq       (rd_eq),
    .rd_gt       (rd_gt),
    .rsp_valid   (rsp_valid),
    .rsp_hop     (rsp_hop),
    .rsp_miss    (rsp_miss)
  );

endmodule

// File: tb/sim_lpm_range_lookup.sv
module sim_lpm_range_lookup;
  localparam int AW = 16, HW = 16, LG = 4, DEPTH = 16, MAXP = 8;
  localparam int unsigned ONES = 32'hFFFF;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          tbl_we = 1'b0;
  logic [LG-1:0] tbl_idx = '0;
  logic [AW-1:0] tbl_key = '0;
  logic [HW-1:0] tbl_eq_hop = '0, tbl_gt_hop = '0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, rsp_valid, rsp_miss;
  logic [HW-1:0] rsp_hop;

  always #2 clk = ~clk;

  lpm_range_lookup u0 (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_key(tbl_key),
    .tbl_eq_hop(tbl_eq_hop), .tbl_gt_hop(tbl_gt_hop), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_hop(rsp_hop), .rsp_miss(rsp_miss)
  );

  int total = 0, bad = 0;
  int unsigned pv[MAXP], ph[MAXP];
  int          pl[MAXP];
  int          np = 0;
  int unsigned tk[DEPTH], te[DEPTH], tg[DEPTH];

  function automatic int unsigned pmask(int len);
    if (len == 0) return 0;
    return (ONES << (AW - len)) & ONES;
  endfunction

  // longest covering prefix, straight from the prefix list
  function automatic int unsigned ref_hop(int unsigned a);
    int bl = -1;
    int unsigned h = 0;
    for (int i = 0; i < np; i++)
      if ((((a ^ pv[i]) & pmask(pl[i])) == 0) && pl[i] > bl) begin
        bl = pl[i];
        h  = ph[i];
      end
    return h;
  endfunction

  function automatic bit ref_miss(int unsigned a);
    for (int i = 0; i < np; i++) if (pv[i] <= a) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string req, string what, int unsigned got, int unsigned exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic load_table();
    int unsigned t;
    for (int i = 0; i < DEPTH; i++) tk[i] = ONES;
    for (int i = 0; i < np; i++) begin
      tk[2*i]   = pv[i];
      tk[2*i+1] = pv[i] | (~pmask(pl[i]) & ONES);
    end
    for (int i = 0; i < DEPTH; i++)
      for (int j = 0; j < DEPTH - 1 - i; j++)
        if (tk[j] > tk[j+1]) begin t = tk[j]; tk[j] = tk[j+1]; tk[j+1] = t; end
    for (int i = 0; i < DEPTH; i++) begin
      te[i] = ref_hop(tk[i]);
      tg[i] = (tk[i] == ONES) ? te[i] : ref_hop(tk[i] + 1);
    end
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_idx = LG'(i); tbl_key = AW'(tk[i]);
      tbl_eq_hop = HW'(te[i]); tbl_gt_hop = HW'(tg[i]);
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic gen_random_set();
    bit dup;
    np = 1 + $urandom_range(MAXP - 1);
    for (int i = 0; i < np; i++) begin
      do begin
        pl[i] = ($urandom_range(9) == 0) ? 0 : 1 + $urandom_range(AW - 1);
        pv[i] = $urandom & pmask(pl[i]);
        dup = 1'b0;
        for (int j = 0; j < i; j++) if (pl[j] == pl[i] && pv[j] == pv[i]) dup = 1'b1;
      end while (dup);
      ph[i] = 1 + $urandom_range(32'hFFFD);
    end
  endtask

  task automatic lookup(int unsigned a, string req);
    int lat;
    int unsigned eh;
    bit em;
    a  = a & ONES;
    em = ref_miss(a);
    eh = em ? 0 : ref_hop(a);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = AW'(a);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", "ready low after accept", req_ready, 0);
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (!rsp_valid && req_ready) check("R2", "ready during search", req_ready, 0);
    end while (!rsp_valid && lat < 40);
    check("R6", "response seen", rsp_valid, 1);
    check(req, "hop", rsp_hop, eh);
    check("R5", "miss flag", rsp_miss, em);
    check("R6", "latency bound", (lat <= LG + 1), 1);
    if (a == tk[0]) check("R6", "slot0 early exit latency", lat, 1);
    check("R2", "ready with response", req_ready, 1);
    @(negedge clk);
    check("R2", "single-cycle response", rsp_valid, 0);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R2", "reset rsp_valid", rsp_valid, 0);
    check("R2", "reset ready", req_ready, 1);
    rst_n = 1'b1;

    // R7 worked case, scaled to 16-bit addresses
    np = 3;
    pl[0] = 1; pv[0] = 32'h8000; ph[0] = 1;
    pl[1] = 3; pv[1] = 32'hA000; ph[1] = 2;
    pl[2] = 5; pv[2] = 32'hA800; ph[2] = 3;
    load_table();
    lookup(32'hAFFF, "R7");
    check("R7", "worked exact", rsp_hop, 3);
    lookup(32'hB800, "R7");
    check("R7", "worked between", rsp_hop, 2);
    lookup(32'hF800, "R7");
    check("R7", "worked outer", rsp_hop, 1);
    lookup(32'h0000, "R5");
    lookup(32'hFFFF, "R8");

    for (int r = 0; r < 24; r++) begin
      gen_random_set();
      load_table();
      lookup($urandom, "R1");
      for (int i = 0; i < DEPTH; i++) begin
        lookup(tk[i], "R3");
        lookup(tk[i] + 1, "R4");
        lookup(tk[i] - 1, "R4");
      end
      lookup(0, "R5");
      lookup(ONES, "R8");
      for (int k = 0; k < 12; k++) lookup($urandom, "R4");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule